// File: doc/BRIEF.md
# Binary-Weighted Bit-Plane PWM Sequencer

This block generates the display timing for a micromirror array whose mirrors can only be fully on or fully off. Each frame is cut into three color slots of equal length: red, then green, then blue. Inside a slot the block steps through the bit-planes of that color from the least significant bit upward. For each plane it announces the plane being shown, as a color code and a bit index. It pulses a load strobe while the array takes in that plane. It then opens an illumination window whose length is the base time unit multiplied by 2^k, where k is the bit index. The time a pixel spends lit therefore reproduces its binary intensity value.

A frame begins on a one-cycle start strobe. The color depth (8, 9 or 10 bits) and the base time unit are sampled on that strobe and held for the whole frame. Plane data comes from a double-buffered store. The block tells the store which half is being read, and it flips the halves only at a frame start that comes after a completed frame, so the writer always fills the half that is not on display. A slot lasts `depth*LOAD_CYCLES + unit*2^depth` cycles. At 120 frames per second each slot gets roughly 2.78 ms, and the unit is chosen so that a slot fills that time.

Top module: `bitplane_seq`

## Requirements
- R1: Within a frame, planes run in the color order red, green, blue (`plane_color` 0, 1, 2). Within each color the bit index runs from 0 up to depth-1. The first cycle of a frame shows color 0, bit 0, with `load_stb` high.
- R2: `depth_sel` encodes the color depth as follows: 0 means 8 bits, 1 means 9, 2 means 10, and 3 is treated as 8.
- R3: Every plane opens with exactly `LOAD_CYCLES` cycles in which `load_stb` is high and `illum_en` is low. The two signals are never high together.
- R4: The load phase of bit k is followed at once by exactly `unit*2^k` consecutive cycles with `illum_en` high.
- R5: After the last plane of each color comes a dark guard of `unit` cycles, with both strobes low and `frame_busy` high. Every slot is therefore `depth*LOAD_CYCLES + unit*2^depth` cycles long.
- R6: A `unit_len` of 0 is treated as 1.
- R7: `depth_sel` and `unit_len` are captured only at an accepted frame start. Changing them during a frame has no effect on that frame.
- R8: A `frame_start` pulse that arrives while `frame_busy` is high is ignored. It does not restart the sequence and does not swap buffers.
- R9: `rd_buf` toggles, with `swap_stb` high for that one cycle, in the first cycle of a frame whose start came after a fully completed frame. The first frame after reset does not swap. `rd_buf` changes at no other time.
- R10: During and right after reset, `frame_busy`, `load_stb`, `illum_en`, `swap_stb` and `rd_buf` are 0.
- R11: The first load cycle is the cycle after the clock edge that samples `frame_start`. `frame_busy` falls in the cycle after the last guard cycle of the blue slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle frame start strobe |
| depth_sel | input | 2 | Color depth code |
| unit_len | input | UNIT_W | Base time unit in clock cycles |
| plane_color | output | 2 | Color of the current plane (0 red, 1 green, 2 blue) |
| plane_bit | output | 4 | Bit index of the current plane |
| load_stb | output | 1 | Array plane-load strobe |
| illum_en | output | 1 | Illumination enable window |
| frame_busy | output | 1 | Frame sequence in progress |
| rd_buf | output | 1 | Buffer half being displayed |
| swap_stb | output | 1 | One-cycle pulse when the buffer halves swap |

## Verification
A corrupted interval count shows up as a load or illumination window that is one or more cycles too long or too short. The bench compares every cycle against the arithmetic schedule, so the fault is seen in the plane where it occurs. A wrong plane or color index appears immediately on `plane_color` or `plane_bit`, and it also shifts every later window, so one error spreads to the rest of the frame. A buffer-control state that has drifted leaves `rd_buf` wrong from the next frame start onward, and this is visible in the first load cycle of that frame.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_ILLUM, ST_GUARD} seq_state_t;

  localparam int unsigned MAX_PLANES = 10;
  localparam int unsigned BIT_W = 4;
  localparam logic [1:0] COL_RED = 2'd0;
  localparam logic [1:0] COL_GRN = 2'd1;
  localparam logic [1:0] COL_BLU = 2'd2;

  // Highest bit index for a depth code (reserved code falls back to 8 bits).
  function automatic logic [BIT_W-1:0] top_bit(input logic [1:0] code);
    case (code)
      2'd1:    top_bit = BIT_W'(8);
      2'd2:    top_bit = BIT_W'(9);
      default: top_bit = BIT_W'(7);
    endcase
  endfunction
endpackage

// File: rtl/bps_cfg_latch.sv
module bps_cfg_latch
  import bps_pkg::*;
#(
  parameter int unsigned UNIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [1:0]        depth_sel,
  input  logic [UNIT_W-1:0] unit_len,
  output logic [BIT_W-1:0]  last_bit,
  output logic [UNIT_W-1:0] unit_eff
);
  logic [BIT_W-1:0]  last_bit_d;
  logic [UNIT_W-1:0] unit_d;

  always_comb begin
    last_bit_d = last_bit;
    unit_d     = unit_eff;
    if (capture) begin
      last_bit_d = top_bit(depth_sel);
      unit_d     = (unit_len == '0) ? UNIT_W'(1) : unit_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_bit <= BIT_W'(7);
      unit_eff <= UNIT_W'(1);
    end else begin
      last_bit <= last_bit_d;
      unit_eff <= unit_d;
    end
  end
endmodule

// File: rtl/bps_interval.sv
module bps_interval #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic             expired
);
  logic [CNT_W-1:0] remain_q, remain_d;

  assign expired = (remain_q == '0);

  always_comb begin
    remain_d = remain_q;
    if (reload)
      remain_d = reload_val;
    else if (!expired)
      remain_d = remain_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain_q <= '0;
    else        remain_q <= remain_d;
  end
endmodule

// File: rtl/bps_buf_ctl.sv
module bps_buf_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok,
  input  logic frame_end,
  output logic rd_buf,
  output logic swap_stb
);
  logic done_q, done_d;
  logic rd_d, swap_d;

  always_comb begin
    done_d = done_q;
    rd_d   = rd_buf;
    swap_d = 1'b0;
    if (frame_end) done_d = 1'b1;
    if (start_ok) begin
      done_d = 1'b0;
      if (done_q) begin
        rd_d   = ~rd_buf;
        swap_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      rd_buf   <= 1'b0;
      swap_stb <= 1'b0;
    end else begin
      done_q   <= done_d;
      rd_buf   <= rd_d;
      swap_stb <= swap_d;
    end
  end
endmodule

// File: rtl/bitplane_seq.sv
module bitplane_seq
  import bps_pkg::*;
#(
  parameter int unsigned UNIT_W      = 8,
  parameter int unsigned LOAD_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [1:0]        depth_sel,
  input  logic [UNIT_W-1:0] unit_len,
  output logic [1:0]        plane_color,
  output logic [3:0]        plane_bit,
  output logic              load_stb,
  output logic              illum_en,
  output logic              frame_busy,
  output logic              rd_buf,
  output logic              swap_stb
);
  localparam int unsigned CNT_W = UNIT_W + MAX_PLANES;
  localparam logic [CNT_W-1:0] LOAD_RELOAD = CNT_W'(LOAD_CYCLES - 1);

  seq_state_t       state_q, state_d;
  logic [1:0]       color_q, color_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             start_ok, frame_end;
  logic             reload, expired;
  logic [CNT_W-1:0] reload_val;
  logic [BIT_W-1:0] last_bit;
  logic [UNIT_W-1:0] unit_eff;
  logic [CNT_W-1:0] illum_len;

  assign start_ok  = (state_q == ST_IDLE) && frame_start;
  assign illum_len = CNT_W'(unit_eff) << bit_q;

  bps_cfg_latch #(.UNIT_W(UNIT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .capture(start_ok),
    .depth_sel(depth_sel), .unit_len(unit_len),
    .last_bit(last_bit), .unit_eff(unit_eff)
  );

  bps_interval #(.CNT_W(CNT_W)) u_ivl (
    .clk(clk), .rst_n(rst_n), .reload(reload),
    .reload_val(reload_val), .expired(expired)
  );

  bps_buf_ctl u_buf (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok),
    .frame_end(frame_end), .rd_buf(rd_buf), .swap_stb(swap_stb)
  );

  always_comb begin
    state_d    = state_q;
    color_d    = color_q;
    bit_d      = bit_q;
    reload     = 1'b0;
    reload_val = LOAD_RELOAD;
    frame_end  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (frame_start) begin
          state_d = ST_LOAD;
          color_d = COL_RED;
          bit_d   = '0;
          reload  = 1'b1;
        end
      end
      ST_LOAD: begin
        if (expired) begin
          state_d    = ST_ILLUM;
          reload     = 1'b1;
          reload_val = illum_len - CNT_W'(1);
        end
      end
      ST_ILLUM: begin
        if (expired) begin
          reload = 1'b1;
          if (bit_q == last_bit) begin
            state_d    = ST_GUARD;
            reload_val = CNT_W'(unit_eff) - CNT_W'(1);
          end else begin
            state_d = ST_LOAD;
            bit_d   = bit_q + BIT_W'(1);
          end
        end
      end
      ST_GUARD: begin
        if (expired) begin
          if (color_q == COL_BLU) begin
            state_d   = ST_IDLE;
            frame_end = 1'b1;
          end else begin
            state_d = ST_LOAD;
            color_d = color_q + 2'd1;
            bit_d   = '0;
            reload  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      color_q <= COL_RED;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      color_q <= color_d;
      bit_q   <= bit_d;
    end
  end

  assign plane_color = color_q;
  assign plane_bit   = bit_q;
  assign load_stb    = (state_q == ST_LOAD);
  assign illum_en    = (state_q == ST_ILLUM);
  assign frame_busy  = (state_q != ST_IDLE);
endmodule

// File: rtl/bps_chk.sv
module bps_chk #(
  parameter int unsigned LOAD_CYCLES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic [1:0] plane_color,
  input logic [3:0] plane_bit,
  input logic       load_stb,
  input logic       illum_en,
  input logic       frame_busy,
  input logic       rd_buf,
  input logic       swap_stb
);
  localparam int unsigned RUN_W = $clog2(LOAD_CYCLES + 2);
  logic [RUN_W-1:0] load_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        load_run <= '0;
    else if (load_stb) load_run <= load_run + RUN_W'(1);
    else               load_run <= '0;
  end

  p_load_illum_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_stb && illum_en));
  p_load_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_stb) |-> load_run == RUN_W'(LOAD_CYCLES));
  p_illum_after_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(illum_en) |-> $past(load_stb));
  p_color_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    plane_color != 2'd3);
  p_bit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    plane_bit <= 4'd9);
  p_frame_begin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_busy) |-> load_stb && plane_color == 2'd0 && plane_bit == 4'd0);
  p_busy_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_busy) |-> $past(frame_start));
  p_swap_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    swap_stb |-> $past(frame_start) && !$past(frame_busy));
  p_swap_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    swap_stb |-> rd_buf != $past(rd_buf));
  p_rdbuf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_stb |-> $stable(rd_buf));
endmodule

bind bitplane_seq bps_chk #(.LOAD_CYCLES(LOAD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .plane_color(plane_color), .plane_bit(plane_bit),
  .load_stb(load_stb), .illum_en(illum_en), .frame_busy(frame_busy),
  .rd_buf(rd_buf), .swap_stb(swap_stb)
);

// File: tb/bitplane_seq_bench.sv
`timescale 1ns/1ps
module bitplane_seq_bench;
  localparam int unsigned UNIT_W = 8;
  localparam int unsigned LOADC  = 2;

  logic clk, rst_n, frame_start;
  logic [1:0] depth_sel;
  logic [UNIT_W-1:0] unit_len;
  logic [1:0] plane_color;
  logic [3:0] plane_bit;
  logic load_stb, illum_en, frame_busy, rd_buf, swap_stb;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit had_frame = 0;
  bit exp_rd = 0;

  bitplane_seq #(.UNIT_W(UNIT_W), .LOAD_CYCLES(LOADC)) u_bitplane_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .depth_sel(depth_sel), .unit_len(unit_len),
    .plane_color(plane_color), .plane_bit(plane_bit),
    .load_stb(load_stb), .illum_en(illum_en), .frame_busy(frame_busy),
    .rd_buf(rd_buf), .swap_stb(swap_stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      if (bad < 25) $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Check one cycle at the sample point, then move to the next sample point.
  task automatic cyc(input int c, input int b, input bit ld, input bit il, input string req);
    int act, exp;
    act = {frame_busy, load_stb, illum_en, plane_color, plane_bit};
    exp = {1'b1, ld, il, 2'(c), 4'(b)};
    chk(act == exp, req, "busy/load/illum/color/bit", act, exp);
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [1:0] code, input int unit, input bit disturb);
    int d, u;
    string rq;
    d = (code == 2'd1) ? 9 : (code == 2'd2) ? 10 : 8;
    u = (unit == 0) ? 1 : unit;
    @(negedge clk);
    depth_sel = code; unit_len = UNIT_W'(unit); frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    if (had_frame) exp_rd = ~exp_rd;
    chk(swap_stb == had_frame, "R9", "swap_stb at frame start", swap_stb, had_frame);
    chk(rd_buf == exp_rd, "R9", "rd_buf at frame start", rd_buf, exp_rd);
    for (int c = 0; c < 3; c++) begin
      for (int b = 0; b < d; b++) begin
        for (int i = 0; i < LOADC; i++) begin
          rq = (c == 0 && b == 0 && i == 0) ? "R11" : (b == 0) ? "R1" : "R3";
          cyc(c, b, 1'b1, 1'b0, rq);
        end
        for (int i = 0; i < (u << b); i++) begin
          if (disturb && c == 1 && b == 2 && i == 0) begin
            frame_start = 1'b1; depth_sel = ~code; unit_len = UNIT_W'(unit + 5);
          end
          if (disturb && c == 1 && b == 2 && i == 1) begin
            frame_start = 1'b0;
            chk(swap_stb == 1'b0, "R8", "swap on busy start", swap_stb, 0);
            chk(rd_buf == exp_rd, "R8", "rd_buf on busy start", rd_buf, exp_rd);
          end
          rq = disturb ? "R7" : (unit == 0) ? "R6" : (code == 2'd3) ? "R2" : "R4";
          cyc(c, b, 1'b0, 1'b1, rq);
        end
      end
      for (int i = 0; i < u; i++) cyc(c, d - 1, 1'b0, 1'b0, (code == 2'd3) ? "R2" : "R5");
    end
    chk({frame_busy, load_stb, illum_en} == 3'b000, "R11", "idle after blue guard",
        {frame_busy, load_stb, illum_en}, 0);
    had_frame = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; depth_sel = 2'd0; unit_len = '0;
    repeat (3) @(negedge clk);
    chk({frame_busy, load_stb, illum_en, swap_stb, rd_buf} == 5'b0, "R10",
        "outputs in reset", {frame_busy, load_stb, illum_en, swap_stb, rd_buf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({frame_busy, load_stb, illum_en, swap_stb, rd_buf} == 5'b0, "R10",
        "outputs after reset", {frame_busy, load_stb, illum_en, swap_stb, rd_buf}, 0);
    run_frame(2'd0, 1, 1'b0);
    run_frame(2'd1, 2, 1'b0);
    run_frame(2'd2, 1, 1'b1);
    run_frame(2'd3, 0, 1'b0);
    repeat (5) @(negedge clk);
    chk(frame_busy == 1'b0 && rd_buf == exp_rd, "R9", "rd_buf held while idle",
        rd_buf, exp_rd);
    run_frame(2'd0, 3, 1'b0);
    run_frame(2'd2, 2, 1'b0);
    run_frame(2'd1, 1, 1'b1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < 190000; n++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule